// File: doc/BRIEF.md
# Configuration Unlock Key Sequencer

This block drives the unlock sequence that moves plug-and-play expansion cards from their waiting state into configuration mode, and it also contains the card-side logic that recognises that sequence. On a start pulse the generator first issues two address writes of value 0x00. These put every listening detector back into a known state. The generator then issues 32 key writes, whose values come from an 8-bit right-shifting linear feedback shift register. Each write is offered on a valid/data pair and is held until the bus master acknowledges it with a ready strobe.

The detector half watches a stream of address-write strobes. It keeps its own copy of the same register and compares every write against the value it expects next. A write that does not match, and any write of 0x00, sends the comparison back to the seed. After 32 consecutive matching writes it raises a one-cycle recognition pulse. In a system the generator sits on the host side and the detector sits on each card. The two halves share one top module so that they can be used and checked together.

Top module: `ikey_top`

## Requirements
- R1: In the cycle after a synchronous reset, `wr_valid`, `busy`, `done` and `key_ok` are all low.
- R2: A `start` pulse while idle begins a run whose first two offered writes carry data 0x00; `wr_valid` rises in the cycle after the edge that sampled `start`.
- R3: The first key byte is 0x6A. Each later key byte is the previous one shifted right by one bit, with bit 7 loaded from bit 1 XOR bit 0 of the previous byte.
- R4: A run consists of exactly 2 zero writes and 32 key writes. After the 32nd key write is accepted, `wr_valid` and `busy` drop, and `done` is high for exactly one cycle, in the cycle after that acceptance.
- R5: A write is accepted only in a cycle where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, the offered data holds and the sequence does not advance.
- R6: `start` is ignored while a run is in progress. The run is not restarted or lengthened.
- R7: In the detector, 32 consecutive strobed writes equal to the key sequence make `key_ok` high for exactly one cycle, in the cycle after the 32nd matching strobe.
- R8: In the detector, a strobed write that differs from the expected byte returns the expectation to 0x6A and is not itself counted as a key byte. The key must then be presented again from its first byte.
- R9: In the detector, a strobed write of 0x00 restarts the comparison from the first key byte.
- R10: In the detector, `det_data` has no effect while `det_wr` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a key run (sampled while idle) |
| wr_ready | input | 1 | Bus master accepts the offered write |
| wr_valid | output | 1 | A write is offered |
| wr_data | output | 8 | Value of the offered address write |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the last key write |
| det_wr | input | 1 | Detector: address-write strobe |
| det_data | input | 8 | Detector: value of the strobed write |
| key_ok | output | 1 | Detector: one-cycle pulse on full key match |

## Verification
The generator's internal state is checked at the ports in two ways.

- A corrupted register state or count shows up within one cycle as a wrong `wr_data` value, a `wr_valid` that stays high or drops at the wrong time, or a `done` that is missing or misplaced. The bench therefore compares every cycle against a model that indexes a precomputed key list.
- A detector that mis-tracks its expectation gives a wrong number of `key_ok` pulses. Such a fault may only become visible up to 32 strobes later, so the bench counts pulses across each scenario as well as comparing every cycle.

The scenarios cover stalled acknowledges, a `start` during a run, a corrupted byte, a mid-key zero write, and data that changes without a strobe.

// File: rtl/ikey_pkg.sv
package ikey_pkg;

    localparam int BYTE_W    = 8;
    localparam int KEY_LEN   = 32;
    localparam int PRE_ZEROS = 2;

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t KEY_SEED = 8'h6A;

    typedef enum logic [1:0] {
        GEN_IDLE,
        GEN_PRE,
        GEN_KEY
    } gen_state_e;

    // Right shift; the new top bit is the XOR of the two lowest bits.
    function automatic byte_t lfsr_next(input byte_t s);
        return {s[1] ^ s[0], s[BYTE_W-1:1]};
    endfunction

endpackage

// File: rtl/ikey_lfsr.sv
module ikey_lfsr
    import ikey_pkg::*;
#(
    parameter byte_t SEED = KEY_SEED
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  step,
    output byte_t state
);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            state <= SEED;
        end else if (step) begin
            state <= lfsr_next(state);
        end
    end

    // A nonzero seed never decays to zero under this feedback.
    p_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        state != '0);

endmodule

// File: rtl/ikey_gen.sv
module ikey_gen
    import ikey_pkg::*;
#(
    parameter int    N_KEY  = KEY_LEN,
    parameter int    N_PRE  = PRE_ZEROS,
    parameter byte_t SEED   = KEY_SEED
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  wr_ready,
    output logic  wr_valid,
    output byte_t wr_data,
    output logic  busy,
    output logic  done
);

    localparam int MAX_N = (N_KEY > N_PRE) ? N_KEY : N_PRE;
    localparam int CNT_W = $clog2(MAX_N + 1);
    localparam logic [CNT_W-1:0] LAST_KEY = CNT_W'(N_KEY - 1);
    localparam logic [CNT_W-1:0] LAST_PRE = CNT_W'((N_PRE > 0) ? N_PRE - 1 : 0);

    gen_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    byte_t            lfsr_val;
    logic             accept;

    assign accept   = wr_valid && wr_ready;
    assign wr_valid = (state_q != GEN_IDLE);
    assign busy     = wr_valid;
    assign wr_data  = (state_q == GEN_KEY) ? lfsr_val : '0;

    ikey_lfsr #(.SEED(SEED)) lfsr_i (
        .clk   (clk),
        .rst   (rst),
        .load  (state_q == GEN_IDLE),
        .step  ((state_q == GEN_KEY) && accept),
        .state (lfsr_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GEN_IDLE;
            cnt_q   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                GEN_IDLE: begin
                    cnt_q <= '0;
                    if (start) begin
                        state_q <= (N_PRE > 0) ? GEN_PRE : GEN_KEY;
                    end
                end
                GEN_PRE: begin
                    if (accept) begin
                        if (cnt_q == LAST_PRE) begin
                            state_q <= GEN_KEY;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                GEN_KEY: begin
                    if (accept) begin
                        if (cnt_q == LAST_KEY) begin
                            state_q <= GEN_IDLE;
                            cnt_q   <= '0;
                            done    <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= GEN_IDLE;
            endcase
        end
    end

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_data));

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> !wr_valid);

    p_start_only_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

endmodule

// File: rtl/ikey_det.sv
module ikey_det
    import ikey_pkg::*;
#(
    parameter int    N_KEY = KEY_LEN,
    parameter byte_t SEED  = KEY_SEED
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  det_wr,
    input  byte_t det_data,
    output logic  key_ok
);

    localparam int CNT_W = $clog2(N_KEY + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(N_KEY - 1);

    logic [CNT_W-1:0] hits_q;
    byte_t            expect_val;
    logic             hit, last_hit;

    assign hit      = det_wr && (det_data != '0) && (det_data == expect_val);
    assign last_hit = hit && (hits_q == LAST);

    ikey_lfsr #(.SEED(SEED)) lfsr_i (
        .clk   (clk),
        .rst   (rst),
        .load  (det_wr && (!hit || last_hit)),
        .step  (hit && !last_hit),
        .state (expect_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hits_q <= '0;
            key_ok <= 1'b0;
        end else begin
            key_ok <= last_hit;
            if (det_wr) begin
                hits_q <= (hit && !last_hit) ? hits_q + 1'b1 : '0;
            end
        end
    end

    p_ok_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        key_ok |=> !key_ok);

    p_ok_from_write_r7: assert property (@(posedge clk) disable iff (rst)
        key_ok |-> $past(det_wr) && ($past(det_data) != '0));

    p_zero_no_ok_r9: assert property (@(posedge clk) disable iff (rst)
        det_wr && (det_data == '0) |=> !key_ok);

    p_idle_no_ok_r10: assert property (@(posedge clk) disable iff (rst)
        !det_wr |=> !key_ok);

endmodule

// File: rtl/ikey_top.sv
module ikey_top
    import ikey_pkg::*;
#(
    parameter int    N_KEY = KEY_LEN,
    parameter int    N_PRE = PRE_ZEROS,
    parameter byte_t SEED  = KEY_SEED
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       wr_ready,
    output logic       wr_valid,
    output logic [7:0] wr_data,
    output logic       busy,
    output logic       done,
    input  logic       det_wr,
    input  logic [7:0] det_data,
    output logic       key_ok
);

    ikey_gen #(.N_KEY(N_KEY), .N_PRE(N_PRE), .SEED(SEED)) gen_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .wr_ready (wr_ready),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .busy     (busy),
        .done     (done)
    );

    ikey_det #(.N_KEY(N_KEY), .SEED(SEED)) det_i (
        .clk      (clk),
        .rst      (rst),
        .det_wr   (det_wr),
        .det_data (det_data),
        .key_ok   (key_ok)
    );

endmodule

// File: tb/ikey_top_tb_top.sv
module ikey_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       wr_ready = 1'b0;
    logic       wr_valid, busy, done, key_ok;
    logic [7:0] wr_data;
    logic       lb = 1'b0;
    logic       tb_dw = 1'b0;
    logic [7:0] tb_dd = 8'h00;
    logic       det_wr;
    logic [7:0] det_data;

    assign det_wr   = lb ? (wr_valid && wr_ready) : tb_dw;
    assign det_data = lb ? wr_data : tb_dd;

    always #5 clk = ~clk;

    ikey_top dut_i (
        .clk(clk), .rst(rst), .start(start), .wr_ready(wr_ready),
        .wr_valid(wr_valid), .wr_data(wr_data), .busy(busy), .done(done),
        .det_wr(det_wr), .det_data(det_data), .key_ok(key_ok)
    );

    int tests = 0;
    int fails = 0;
    int keyq [32];

    // Reference model state
    bit m_act = 0;
    int m_idx = 0;
    bit m_done = 0;
    int m_dcnt = 0;
    bit m_ok = 0;

    // Monitor counters
    int acc_n = 0, done_n = 0, ok_n = 0, first_key = -1, key_n = 0;
    bit prev_stall = 0;
    int prev_data = 0;

    task automatic chk(input bit good, input string req, input int act, input int exp);
        tests++;
        if (!good) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    initial begin
        int s = 'h6A;
        for (int k = 0; k < 32; k++) begin
            keyq[k] = s;
            s = (s / 2) + ((((s / 2) % 2) ^ (s % 2)) * 128);
        end
    end

    always @(posedge clk) begin
        bit nd, no;
        if (rst) begin
            m_act = 0; m_idx = 0; m_done = 0; m_dcnt = 0; m_ok = 0;
        end else begin
            nd = 0; no = 0;
            if (m_act && wr_ready) begin
                if (m_idx == 33) begin m_act = 0; nd = 1; end
                else m_idx++;
            end else if (!m_act && start) begin
                m_act = 1; m_idx = 0;
            end
            m_done = nd;
            if (det_wr) begin
                if (det_data != 0 && int'(det_data) == keyq[m_dcnt]) begin
                    if (m_dcnt == 31) begin no = 1; m_dcnt = 0; end
                    else m_dcnt++;
                end else m_dcnt = 0;
            end
            m_ok = no;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            int ed;
            ed = (m_idx < 2) ? 0 : keyq[m_idx - 2];
            chk(wr_valid == m_act, "R2 wr_valid", wr_valid, m_act);
            chk(busy == m_act, "R6 busy", busy, m_act);
            if (m_act) chk(int'(wr_data) == ed, "R3 wr_data", wr_data, ed);
            chk(done == m_done, "R4 done", done, m_done);
            chk(key_ok == m_ok, "R7 key_ok", key_ok, m_ok);
            if (prev_stall) begin
                chk(wr_valid && int'(wr_data) == prev_data, "R5 hold", wr_data, prev_data);
            end
            prev_stall = wr_valid && !wr_ready;
            prev_data  = wr_data;
            if (wr_valid && wr_ready) begin
                if (acc_n == 2) first_key = wr_data;
                if (acc_n >= 2) key_n++;
                acc_n++;
            end
            if (done) done_n++;
            if (key_ok) ok_n++;
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic clr_mon();
        acc_n = 0; done_n = 0; ok_n = 0; first_key = -1; key_n = 0;
    endtask

    task automatic run_gen(input int mode);
        clr_mon();
        lb = 1;
        start = 1;
        tick();
        start = 0;
        for (int i = 0; i < 400 && done_n == 0; i++) begin
            case (mode)
                0: wr_ready = 1;
                1: wr_ready = (i % 3 != 2);
                default: wr_ready = (i % 4 == 0);
            endcase
            start = (i == 5);  // R6: start while busy
            tick();
        end
        start = 0;
        wr_ready = 0;
        repeat (3) tick();
        chk(acc_n == 34, "R4 total writes", acc_n, 34);
        chk(key_n == 32, "R4 key writes", key_n, 32);
        chk(first_key == 'h6A, "R3 first key byte", first_key, 'h6A);
        chk(done_n == 1, "R4 done count", done_n, 1);
        chk(wr_valid == 0 && busy == 0, "R6 idle after run", busy, 0);
        chk(ok_n == 1, "R7 loopback key_ok", ok_n, 1);
        lb = 0;
    endtask

    task automatic send(input int b);
        tb_dw = 1; tb_dd = 8'(b);
        tick();
        tb_dw = 0; tb_dd = 8'h6A;  // R10: unstrobed data that would match
        tick();
    endtask

    task automatic run_all();
        repeat (3) tick();
        chk(wr_valid == 0 && busy == 0 && done == 0 && key_ok == 0, "R1 reset", {wr_valid, busy, done, key_ok}, 0);
        rst = 0;
        tick();
        chk(wr_valid == 0 && key_ok == 0, "R1 after release", {wr_valid, key_ok}, 0);
        run_gen(0);
        run_gen(1);
        run_gen(2);

        // R7 / R10: clean key with garbage between strobes
        clr_mon();
        for (int k = 0; k < 32; k++) send(keyq[k]);
        tick();
        chk(ok_n == 1, "R7 R10 clean key", ok_n, 1);

        // R8: corrupted byte mid-key, then the rest of the key
        clr_mon();
        for (int k = 0; k < 10; k++) send(keyq[k]);
        send('h55);
        for (int k = 10; k < 32; k++) send(keyq[k]);
        tick();
        chk(ok_n == 0, "R8 mismatch breaks key", ok_n, 0);
        for (int k = 0; k < 32; k++) send(keyq[k]);
        tick();
        chk(ok_n == 1, "R8 key after mismatch", ok_n, 1);

        // R9: zero write mid-key restarts
        clr_mon();
        for (int k = 0; k < 20; k++) send(keyq[k]);
        send(0);
        for (int k = 20; k < 32; k++) send(keyq[k]);
        tick();
        chk(ok_n == 0, "R9 zero restarts", ok_n, 0);
        send(0);
        for (int k = 0; k < 32; k++) send(keyq[k]);
        tick();
        chk(ok_n == 1, "R9 key after zero", ok_n, 1);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                tests++;
                fails++;
                $display("FAIL R4 watchdog: actual hung expected finish");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule